// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the device side of a receive descriptor ring in host memory. Each descriptor is 16 bytes. The word at offset 0 is the status/control word and the word at offset 8 holds the buffer address. Software arms a descriptor by setting the owner bit and writing the buffer size into the low bits of the status word. It marks the last descriptor of the ring with an end-of-ring bit.

The block reads the current descriptor ahead of time through a single memory port. It then takes a frame from a byte stream, which carries valid, last and error flags and has no back-pressure. The frame bytes go into the descriptor's buffer one byte lane at a time. When the frame ends, the block writes back a status word that gives the stored length and the error flags, with the owner bit cleared. It then moves to the next descriptor, or back to the ring base after an end-of-ring descriptor.

A frame that cannot be placed is dropped and counted as missed. This happens when the descriptor is not owned by the device, or when the frame starts while the block is still fetching a descriptor or writing one back. Sticky interrupt status bits report each outcome.

Top module: `rxr_writer`

## Requirements
- R1: After reset, irq_o and missed_o are 0 and the first two memory reads go to ring_base_i (status word) and ring_base_i+8 (buffer address).
- R2: The bytes of a frame placed in an owned descriptor are written to consecutive byte addresses starting at the buffer address. Each byte write has a one-hot mem_be_o equal to 1 << addr[1:0], and the byte is repeated in all four lanes of mem_wdata_o.
- R3: At the end of a frame, one full-word write (mem_be_o=4'hF) to the descriptor's offset 0 returns the status word. In that word, bit 31 (owner) is 0, bits 29 and 28 (first/last segment) are 1, bit 30 (end-of-ring) is copied from the descriptor, and bits 12:0 hold the stored byte count.
- R4: Each writeback advances the descriptor address by 16. After a descriptor with bit 30 set, the next descriptor is at ring_base_i.
- R5: If rx_err_i is high with the last byte, status bits 19 (CRC) and 21 (error summary) are set, and irq_o bit 1 is set instead of bit 0.
- R6: A frame shorter than RUNT_LEN bytes (64) sets status bits 20 (runt) and 21.
- R7: The limit is the smaller of the descriptor's buffer size (status bits 12:0) and max_len_i. For a frame longer than the limit, bytes beyond the limit are not written, the length field equals the limit, and status bits 22 (overlong) and 21 are set.
- R8: A frame that starts while the current descriptor is not owned is not written to memory. It increments missed_o and sets irq_o bit 4. The descriptor does not advance, and it is re-polled until software arms it.
- R9: A frame that starts while the block is fetching a descriptor or writing one back is dropped. It increments missed_o and sets irq_o bit 6, and the writeback in progress still completes.
- R10: irq_o bits are sticky. Writing a 1 in irq_clr_i clears that bit only, and a set in the same cycle wins.
- R11: A frame of at least 64 bytes, within the limit and without error, sets irq_o bit 0 and leaves status bits 22:19 clear. Only irq_o bits 0, 1, 4 and 6 can ever be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_base_i | input | AW | Byte address of descriptor 0 |
| max_len_i | input | 16 | Maximum accepted frame size in bytes |
| rx_valid_i | input | 1 | Stream byte valid |
| rx_data_i | input | 8 | Stream byte |
| rx_last_i | input | 1 | Last byte of frame |
| rx_err_i | input | 1 | CRC error, sampled with the last byte |
| irq_clr_i | input | 8 | Write-one-to-clear for irq_o |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after the request |
| irq_o | output | 8 | Sticky interrupt status |
| missed_o | output | CNT_W | Dropped frame count |

## Verification
The bench walks a four-descriptor ring all the way around, so that the wrap after the end-of-ring descriptor lands on a descriptor that has already been handed back. If the owner check were missing, that frame would overwrite the buffer; if the wrap were wrong, it would be written past the ring. An overlong frame is followed by a check of a sentinel byte just past the limit, which catches a missing truncation or a length field that counts all received bytes. A frame started one idle cycle after the previous one checks that the writeback already under way is not lost, and that the dropped frame neither advances the ring nor is reported as a missing descriptor.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int OWN_B  = 31;
  localparam int EOR_B  = 30;
  localparam int FS_B   = 29;
  localparam int LS_B   = 28;
  localparam int RWT_B  = 22;
  localparam int RES_B  = 21;
  localparam int RUNT_B = 20;
  localparam int CRC_B  = 19;
  localparam int LEN_W  = 13;
  localparam int IRQ_W      = 8;
  localparam int IRQ_OK     = 0;
  localparam int IRQ_ERR    = 1;
  localparam int IRQ_NODESC = 4;
  localparam int IRQ_BUSY   = 6;
  localparam int DESC_BYTES = 16;
  localparam int ADDR_OFS   = 8;

  typedef enum logic [2:0] {
    S_RD_STS, S_RD_ADR, S_LATCH, S_READY, S_RECV, S_DROP, S_WB
  } rxr_state_e;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW = 32,
  parameter int STEP_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          eor_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] STEP = AW'(STEP_BYTES);
  logic [AW-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    off_q <= '0;
    else if (adv_i) off_q <= eor_i ? '0 : off_q + STEP;
  end

  assign addr_o = base_i + off_q;
endmodule

// File: rtl/rxr_stat_gen.sv
module rxr_stat_gen
  import rxr_pkg::*;
#(
  parameter int CW = 16,
  parameter int RUNT_LEN = 64
) (
  input  logic [CW-1:0]    cnt_i,
  input  logic [LEN_W-1:0] limit_i,
  input  logic             crc_i,
  input  logic             eor_i,
  output logic [31:0]      word_o,
  output logic             err_o
);
  logic over, runt;
  logic [LEN_W-1:0] len;

  always_comb begin
    over  = cnt_i > CW'(limit_i);
    runt  = cnt_i < CW'(RUNT_LEN);
    len   = over ? limit_i : cnt_i[LEN_W-1:0];
    err_o = over | runt | crc_i;
    word_o = '0;
    word_o[EOR_B]  = eor_i;
    word_o[FS_B]   = 1'b1;
    word_o[LS_B]   = 1'b1;
    word_o[RWT_B]  = over;
    word_o[RES_B]  = err_o;
    word_o[RUNT_B] = runt;
    word_o[CRC_B]  = crc_i;
    word_o[LEN_W-1:0] = len;
  end
endmodule

// File: rtl/rxr_irq.sv
module rxr_irq #(
  parameter int IW = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IW-1:0]    set_i,
  input  logic [IW-1:0]    clr_i,
  input  logic             miss_i,
  output logic [IW-1:0]    irq_o,
  output logic [CNT_W-1:0] missed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o    <= '0;
      missed_o <= '0;
    end else begin
      irq_o <= (irq_o & ~clr_i) | set_i;
      if (miss_i) missed_o <= missed_o + 1'b1;
    end
  end
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
  import rxr_pkg::*;
#(
  parameter int AW = 32,
  parameter int CNT_W = 16,
  parameter int RUNT_LEN = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    ring_base_i,
  input  logic [15:0]      max_len_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_last_i,
  input  logic             rx_err_i,
  input  logic [7:0]       irq_clr_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [3:0]       mem_be_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i,
  output logic [7:0]       irq_o,
  output logic [CNT_W-1:0] missed_o
);
  localparam int CW = 16;
  localparam logic [CW-1:0] CNT_MAX = '1;

  rxr_state_e st_q, st_d;
  logic own_q, own_d, eor_q, eor_d, crc_q, crc_d, nodesc_q, nodesc_d;
  logic [LEN_W-1:0] size_q, size_d, limit;
  logic [AW-1:0] buf_q, buf_d, desc_addr, wr_addr;
  logic [CW-1:0] cnt_q, cnt_d, idx;
  logic adv, miss, stat_err, fetching;
  logic [IRQ_W-1:0] irq_set;
  logic [31:0] stat_word;

  rxr_ring_ptr #(.AW(AW), .STEP_BYTES(DESC_BYTES)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_i(ring_base_i),
    .adv_i(adv), .eor_i(eor_q), .addr_o(desc_addr)
  );

  rxr_stat_gen #(.CW(CW), .RUNT_LEN(RUNT_LEN)) u_stat (
    .cnt_i(cnt_q), .limit_i(limit), .crc_i(crc_q), .eor_i(eor_q),
    .word_o(stat_word), .err_o(stat_err)
  );

  rxr_irq #(.IW(IRQ_W), .CNT_W(CNT_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(irq_set), .clr_i(irq_clr_i),
    .miss_i(miss), .irq_o(irq_o), .missed_o(missed_o)
  );

  assign limit = (max_len_i < 16'(size_q)) ? max_len_i[LEN_W-1:0] : size_q;
  assign fetching = (st_q == S_RD_STS) || (st_q == S_RD_ADR) ||
                    (st_q == S_LATCH) || (st_q == S_WB);
  assign idx = (st_q == S_READY) ? '0 : cnt_q;
  assign wr_addr = buf_q + AW'(idx);

  always_comb begin
    st_d = st_q; own_d = own_q; eor_d = eor_q; size_d = size_q;
    buf_d = buf_q; cnt_d = cnt_q; crc_d = crc_q; nodesc_d = nodesc_q;
    mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = desc_addr;
    mem_be_o = '0; mem_wdata_o = '0;
    adv = 1'b0; miss = 1'b0; irq_set = '0;
    case (st_q)
      S_RD_STS: begin
        mem_req_o = 1'b1;
        st_d = S_RD_ADR;
      end
      S_RD_ADR: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_addr + AW'(ADDR_OFS);
        own_d  = mem_rdata_i[OWN_B];
        eor_d  = mem_rdata_i[EOR_B];
        size_d = mem_rdata_i[LEN_W-1:0];
        st_d = S_LATCH;
      end
      S_LATCH: begin
        buf_d    = mem_rdata_i[AW-1:0];
        nodesc_d = !own_q;
        st_d     = own_q ? S_READY : S_RD_STS;  // keep polling until armed
      end
      S_READY, S_RECV: begin
        if (rx_valid_i) begin
          if (idx < CW'(limit)) begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = wr_addr;
            mem_be_o    = 4'b0001 << wr_addr[1:0];
            mem_wdata_o = {4{rx_data_i}};
          end
          cnt_d = (idx == CNT_MAX) ? idx : idx + 1'b1;
          if (rx_last_i) begin
            crc_d = rx_err_i;
            st_d  = S_WB;
          end else begin
            st_d = S_RECV;
          end
        end
      end
      S_DROP: if (rx_valid_i && rx_last_i) st_d = S_RD_STS;
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = 4'hF;
        mem_wdata_o = stat_word;
        adv         = 1'b1;
        irq_set[stat_err ? IRQ_ERR : IRQ_OK] = 1'b1;
        st_d = S_RD_STS;
      end
      default: st_d = S_RD_STS;
    endcase
    // frame start while no descriptor is ready to receive it
    if (fetching && rx_valid_i) begin
      miss = 1'b1;
      irq_set[nodesc_q ? IRQ_NODESC : IRQ_BUSY] = 1'b1;
      st_d = rx_last_i ? S_RD_STS : S_DROP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_RD_STS; own_q <= 1'b0; eor_q <= 1'b0; size_q <= '0;
      buf_q <= '0; cnt_q <= '0; crc_q <= 1'b0; nodesc_q <= 1'b0;
    end else begin
      st_q <= st_d; own_q <= own_d; eor_q <= eor_d; size_q <= size_d;
      buf_q <= buf_d; cnt_q <= cnt_d; crc_q <= crc_d; nodesc_q <= nodesc_d;
    end
  end
endmodule

// File: rtl/rxr_writer_chk.sv
module rxr_writer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [15:0]      max_len_i,
  input logic [7:0]       irq_clr_i,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [1:0]       addr_lo,
  input logic [3:0]       mem_be_o,
  input logic [31:0]      mem_wdata_o,
  input logic [7:0]       irq_o,
  input logic [CNT_W-1:0] missed_o
);
  logic wb, bw;
  assign wb = mem_req_o && mem_we_o && (mem_be_o == 4'hF);
  assign bw = mem_req_o && mem_we_o && (mem_be_o != 4'hF);

  a_r3_own_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb |-> (!mem_wdata_o[31] && mem_wdata_o[29] && mem_wdata_o[28]));

  a_r5_err_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb |-> (mem_wdata_o[21] == (mem_wdata_o[22] | mem_wdata_o[20] | mem_wdata_o[19])));

  a_r2_byte_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bw |-> ($onehot(mem_be_o) && mem_be_o == (4'b0001 << addr_lo)));

  a_r2_byte_rep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bw |-> (mem_wdata_o == {4{mem_wdata_o[7:0]}}));

  a_r7_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb |-> ({3'b000, mem_wdata_o[12:0]} <= max_len_i));

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i == 8'h00) |=> ((irq_o & $past(irq_o)) == $past(irq_o)));

  a_r8_missed_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(missed_o) |-> (missed_o == $past(missed_o) + 1'b1));

  a_r11_irq_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & 8'hAC) == 8'h00);
endmodule

bind rxr_writer rxr_writer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .max_len_i(max_len_i), .irq_clr_i(irq_clr_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .addr_lo(mem_addr_o[1:0]),
  .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .irq_o(irq_o),
  .missed_o(missed_o)
);

// File: tb/tb_rxr_writer.sv
`timescale 1ns/1ps
module tb_rxr_writer;
  localparam int AW = 32;
  localparam int CNT_W = 16;
  localparam logic [31:0] RING = 32'h100;
  localparam logic [31:0] BUFB = 32'h1000;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] EOR = 32'h4000_0000;
  localparam logic [31:0] FSLS = 32'h3000_0000;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] ring_base = RING;
  logic [15:0] max_len = 16'h0800;
  logic rx_valid = 0, rx_last = 0, rx_err = 0;
  logic [7:0] rx_data = 0, irq_clr = 0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0] irq;
  logic [CNT_W-1:0] missed;

  int total = 0, bad = 0, wr_cnt = 0, rd_n = 0;
  logic [31:0] rd_log [0:1];
  logic [31:0] mem [0:2047];

  always #5 clk = ~clk;

  rxr_writer #(.AW(AW), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ring_base_i(ring_base), .max_len_i(max_len),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
    .rx_err_i(rx_err), .irq_clr_i(irq_clr), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .irq_o(irq),
    .missed_o(missed)
  );

  always @(posedge clk) begin
    if (rst_n && mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[12:2]][8*b +: 8] = mem_wdata[8*b +: 8];
        wr_cnt = wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[12:2]];
        if (rd_n < 2) begin
          rd_log[rd_n] = mem_addr;
          rd_n = rd_n + 1;
        end
      end
    end
  end

  function automatic logic [7:0] rdb(input logic [31:0] a);
    return mem[a[12:2]][8*a[1:0] +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic arm(input int i, input logic [31:0] size);
    mem[(RING[12:2]) + 4*i] = OWN | ((i == 3) ? EOR : 32'h0) | size;
    mem[(RING[12:2]) + 4*i + 2] = BUFB + 32'(i) * 32'h100;
  endtask

  task automatic send(input int len, input logic [7:0] seed, input bit err);
    for (int k = 0; k < len; k++) begin
      @(posedge clk); #1;
      rx_valid = 1; rx_data = seed + 8'(k);
      rx_last = (k == len - 1); rx_err = err && (k == len - 1);
    end
    @(posedge clk); #1;
    rx_valid = 0; rx_last = 0; rx_err = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_buf(input logic [31:0] base, input int len,
                         input logic [7:0] seed, input string req);
    int errs = 0;
    logic [7:0] first_bad_a = 0, first_bad_e = 0;
    for (int k = 0; k < len; k++)
      if (rdb(base + 32'(k)) !== seed + 8'(k)) begin
        if (errs == 0) begin
          first_bad_a = rdb(base + 32'(k));
          first_bad_e = seed + 8'(k);
        end
        errs++;
      end
    chk(errs == 0, req, "buffer bytes", {24'h0, first_bad_a}, {24'h0, first_bad_e});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(irq == 0, "R1", "irq after reset", {24'h0, irq}, 0);
    chk(missed == 0, "R1", "missed after reset", {16'h0, missed}, 0);
    rst_n = 1;
    idle(6);
    chk(rd_log[0] == RING, "R1", "first read addr", rd_log[0], RING);
    chk(rd_log[1] == RING + 8, "R1", "second read addr", rd_log[1], RING + 8);
  endtask

  task automatic t_clean;
    send(100, 8'h00, 0); idle(8);
    chk_buf(BUFB, 100, 8'h00, "R2");
    chk(mem[RING[12:2]] == (FSLS | 32'd100), "R3 R11", "desc0 status",
        mem[RING[12:2]], FSLS | 32'd100);
    chk(irq == 8'h01, "R11", "irq ok", {24'h0, irq}, 1);
    irq_clr = 8'h01; @(posedge clk); #1; irq_clr = 0; @(negedge clk);
    chk(irq == 8'h00, "R10", "irq cleared", {24'h0, irq}, 0);
  endtask

  task automatic t_crc;
    send(80, 8'h20, 1); idle(8);
    chk_buf(BUFB + 32'h100, 80, 8'h20, "R4");
    chk(mem[RING[12:2] + 4] == (FSLS | 32'h0028_0000 | 32'd80), "R5", "desc1 status",
        mem[RING[12:2] + 4], FSLS | 32'h0028_0000 | 32'd80);
    chk(irq == 8'h02, "R5", "irq err", {24'h0, irq}, 2);
  endtask

  task automatic t_runt;
    send(30, 8'h50, 0); idle(8);
    chk(mem[RING[12:2] + 8] == (FSLS | 32'h0030_0000 | 32'd30), "R6", "desc2 status",
        mem[RING[12:2] + 8], FSLS | 32'h0030_0000 | 32'd30);
  endtask

  task automatic t_long;
    send(250, 8'h10, 0); idle(8);
    chk(mem[RING[12:2] + 12] == (EOR | FSLS | 32'h0060_0000 | 32'd200), "R7 R3",
        "desc3 status", mem[RING[12:2] + 12], EOR | FSLS | 32'h0060_0000 | 32'd200);
    chk_buf(BUFB + 32'h300, 200, 8'h10, "R7");
    chk(rdb(BUFB + 32'h300 + 200) == 8'hEE, "R7", "byte past limit",
        {24'h0, rdb(BUFB + 32'h300 + 200)}, 32'hEE);
  endtask

  task automatic t_noown;
    int w0;
    w0 = wr_cnt;
    send(20, 8'h33, 0); idle(4);
    chk(wr_cnt == w0, "R8", "writes during drop", wr_cnt, w0);
    chk(missed == 1, "R8", "missed count", {16'h0, missed}, 1);
    chk(irq == 8'h12, "R8", "irq nodesc", {24'h0, irq}, 32'h12);
    irq_clr = 8'h02; @(posedge clk); #1; irq_clr = 0; @(negedge clk);
    chk(irq == 8'h10, "R10", "clear only bit1", {24'h0, irq}, 32'h10);
    irq_clr = 8'hFF; @(posedge clk); #1; irq_clr = 0;
    arm(0, 32'd200);
    idle(8);
    send(70, 8'h40, 0); idle(8);
    chk(mem[RING[12:2]] == (FSLS | 32'd70), "R4 R8", "desc0 after wrap",
        mem[RING[12:2]], FSLS | 32'd70);
    chk_buf(BUFB, 70, 8'h40, "R4");
  endtask

  task automatic t_busy;
    arm(1, 32'd200); arm(2, 32'd200);
    irq_clr = 8'hFF; @(posedge clk); #1; irq_clr = 0;
    idle(8);
    send(64, 8'h80, 0);
    send(10, 8'h77, 0);
    idle(8);
    chk(mem[RING[12:2] + 4] == (FSLS | 32'd64), "R9", "desc1 writeback kept",
        mem[RING[12:2] + 4], FSLS | 32'd64);
    chk(missed == 2, "R9", "missed count", {16'h0, missed}, 2);
    chk(irq == 8'h41, "R9", "irq busy", {24'h0, irq}, 32'h41);
    send(65, 8'hC0, 0); idle(8);
    chk(mem[RING[12:2] + 8] == (FSLS | 32'd65), "R9", "desc2 not skipped",
        mem[RING[12:2] + 8], FSLS | 32'd65);
    chk_buf(BUFB + 32'h200, 65, 8'hC0, "R9");
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 32'hEEEE_EEEE;
    for (int i = 0; i < 4; i++) arm(i, 32'd200);
    repeat (5) @(posedge clk);
    t_reset;
    t_clean;
    t_crc;
    t_runt;
    t_long;
    t_noown;
    t_busy;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule